// File: doc/BRIEF.md
# GPIO Pad Event Controller

This block watches a bank of GPIO pad inputs and turns configured input activity into sticky interrupt and wake status bits. Each pad has a two-bit event mode (level, single edge, both edges or off) and an inversion bit. With inversion, single-edge mode catches falling edges and level mode catches an active-low input. The asynchronous pad inputs are synchronised before any detection takes place.

Status bits are grouped into 32-bit words, one word per pad group. Each status word has an enable word beside it. One shared interrupt line is raised while any status bit has its enable bit set. A second, independent status/enable pair records wake events. A pad's wake status feeds the wake output only if the pad is not routed to the system-control interrupt path. Pads held by firmware, shown by a clear host-ownership bit, never update interrupt status, but their wake status still records events. Software reaches the four register sets through a single-cycle read/write port.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: The event mode of pad p sits in `evt_mode_i[2p+1:2p]`. The codes are 0 = level, 1 = single edge, 2 = off and 3 = both edges. A pad in mode 2 sets neither its interrupt status nor its wake status.
- R2: In mode 1 with `rx_inv_i[p]=0`, only a rising pad edge sets status. With `rx_inv_i[p]=1`, only a falling edge sets status.
- R3: In mode 3, both rising and falling pad edges set status, whatever the inversion bit.
- R4: In mode 0, status is set on every cycle in which the inverted input (`pad ^ rx_inv`) is 1. A clear during that time does not take effect. With inversion, a low pad is the active level.
- R5: Interrupt status for group g is read at 0x100+4g. Pad p maps to group p/GRP_SIZE, bit p%GRP_SIZE. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An event on the same bit in the same cycle as a clear keeps the bit set.
- R6: Interrupt enable for group g is at 0x120+4g. `irq_o` is 1 exactly when some interrupt status bit and its enable bit are both 1.
- R7: Wake status for group g is at 0x140+4g and is write-1-to-clear. Wake enable is at 0x160+4g. `wake_o` is 1 exactly when some pad has wake status 1, wake enable 1 and `route_sci_i` 0.
- R8: A pad with `host_own_i[p]=0` never sets its interrupt status bit. Its wake status bit is still set by its events.
- R9: Bits for pads at or above NUM_PADS in the last group read as 0, and writes to them are ignored.
- R10: After reset, every status and enable word reads 0, and `irq_o` and `wake_o` are 0.
- R11: A pad change is visible in status after the third rising clock edge and not after the second. The first two edges pass through the synchroniser and the third loads status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pad_i | input | NUM_PADS | Asynchronous pad input values |
| evt_mode_i | input | 2*NUM_PADS | Per-pad event mode, two bits per pad |
| rx_inv_i | input | NUM_PADS | Per-pad input inversion |
| host_own_i | input | NUM_PADS | 1 = pad owned by host, 0 = firmware |
| route_sci_i | input | NUM_PADS | 1 = pad routed to system-control interrupt, blocks wake |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Shared interrupt line |
| wake_o | output | 1 | Wake request |

## Verification
The assertions assume that the per-pad configuration (mode, inversion and ownership) is stable for the cycle before it is sampled. This is needed because the checks on off-mode and firmware pads compare newly set status against the previous cycle's configuration. They also assume that status bits can drop only through a register write. The stimulus changes configuration only at falling clock edges, and only while the affected pad is idle or in the off mode. It brings a level-mode pad to its inactive level before any clear whose effect is checked.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_EDGE  = 2'd1,
    EVT_OFF   = 2'd2,
    EVT_BOTH  = 2'd3
  } evt_mode_e;

  localparam logic [11:0] OFS_INT_STS  = 12'h100;
  localparam logic [11:0] OFS_INT_EN   = 12'h120;
  localparam logic [11:0] OFS_WAKE_STS = 12'h140;
  localparam logic [11:0] OFS_WAKE_EN  = 12'h160;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PADS-1:0]   pad_s_i,
  input  logic [2*NUM_PADS-1:0] mode_i,
  input  logic [NUM_PADS-1:0]   inv_i,
  output logic [NUM_PADS-1:0]   evt_o
);
  logic [NUM_PADS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pad_s_i;
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic      cur, prv;
    evt_mode_e mode;
    assign cur  = pad_s_i[p] ^ inv_i[p];
    assign prv  = prev_q[p] ^ inv_i[p];
    assign mode = evt_mode_e'(mode_i[2*p +: 2]);

    always_comb begin
      unique case (mode)
        EVT_LEVEL: evt_o[p] = cur;
        EVT_EDGE:  evt_o[p] = cur & ~prv;
        EVT_BOTH:  evt_o[p] = pad_s_i[p] ^ prev_q[p];
        default:   evt_o[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int NUM_PADS = 8,
  parameter int GRP_SIZE = 32,
  parameter int NUM_GRPS = 1,
  parameter int GW       = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] set_i,
  input  logic                sts_we_i,
  input  logic                en_we_i,
  input  logic [GW-1:0]       grp_i,
  input  logic [31:0]         wdata_i,
  output logic [NUM_PADS-1:0] sts_o,
  output logic [NUM_PADS-1:0] en_o
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_bit
    localparam int G = p / GRP_SIZE;
    localparam int B = p % GRP_SIZE;
    logic hit;
    assign hit = (grp_i == GW'(G)) && wdata_i[B];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_o[p] <= 1'b0;
        en_o[p]  <= 1'b0;
      end else begin
        // a new event outranks a same-cycle clear
        sts_o[p] <= (sts_o[p] & ~(sts_we_i & hit)) | set_i[p];
        if (en_we_i && grp_i == GW'(G)) en_o[p] <= wdata_i[B];
      end
    end
  end
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 40,
  parameter int GRP_SIZE = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PADS-1:0]   pad_i,
  input  logic [2*NUM_PADS-1:0] evt_mode_i,
  input  logic [NUM_PADS-1:0]   rx_inv_i,
  input  logic [NUM_PADS-1:0]   host_own_i,
  input  logic [NUM_PADS-1:0]   route_sci_i,
  input  logic                  reg_we_i,
  input  logic [11:0]           reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  irq_o,
  output logic                  wake_o
);
  localparam int NUM_GRPS = (NUM_PADS + GRP_SIZE - 1) / GRP_SIZE;
  localparam int GW       = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1;
  localparam int PAD_W    = NUM_GRPS * GRP_SIZE;

  logic [NUM_PADS-1:0] pad_s, evt;
  logic [NUM_PADS-1:0] int_sts, int_en, wake_sts, wake_en;
  logic                acc_ok;
  logic [6:0]          blk;
  logic [GW-1:0]       grp;
  int                  grp_idx;

  gpio_evt_sync #(.W(NUM_PADS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pad_s)
  );

  gpio_evt_detect #(.NUM_PADS(NUM_PADS)) u_det (
    .clk_i, .rst_ni, .pad_s_i(pad_s), .mode_i(evt_mode_i),
    .inv_i(rx_inv_i), .evt_o(evt)
  );

  assign acc_ok  = (reg_addr_i[1:0] == 2'b00) && (32'(reg_addr_i[4:2]) < NUM_GRPS);
  assign blk     = reg_addr_i[11:5];
  assign grp     = reg_addr_i[2 +: GW];
  assign grp_idx = 32'(grp);

  gpio_evt_bank #(.NUM_PADS(NUM_PADS), .GRP_SIZE(GRP_SIZE), .NUM_GRPS(NUM_GRPS), .GW(GW)) u_int (
    .clk_i, .rst_ni,
    .set_i   (evt & host_own_i),
    .sts_we_i(reg_we_i && acc_ok && blk == OFS_INT_STS[11:5]),
    .en_we_i (reg_we_i && acc_ok && blk == OFS_INT_EN[11:5]),
    .grp_i   (grp),
    .wdata_i (reg_wdata_i),
    .sts_o   (int_sts),
    .en_o    (int_en)
  );

  gpio_evt_bank #(.NUM_PADS(NUM_PADS), .GRP_SIZE(GRP_SIZE), .NUM_GRPS(NUM_GRPS), .GW(GW)) u_wake (
    .clk_i, .rst_ni,
    .set_i   (evt),
    .sts_we_i(reg_we_i && acc_ok && blk == OFS_WAKE_STS[11:5]),
    .en_we_i (reg_we_i && acc_ok && blk == OFS_WAKE_EN[11:5]),
    .grp_i   (grp),
    .wdata_i (reg_wdata_i),
    .sts_o   (wake_sts),
    .en_o    (wake_en)
  );

  logic [PAD_W-1:0] sel_vec;
  always_comb begin
    sel_vec = '0;
    unique case (blk)
      OFS_INT_STS[11:5]:  sel_vec[NUM_PADS-1:0] = int_sts;
      OFS_INT_EN[11:5]:   sel_vec[NUM_PADS-1:0] = int_en;
      OFS_WAKE_STS[11:5]: sel_vec[NUM_PADS-1:0] = wake_sts;
      OFS_WAKE_EN[11:5]:  sel_vec[NUM_PADS-1:0] = wake_en;
      default:            sel_vec = '0;
    endcase
  end

  always_comb begin
    reg_rdata_o = '0;
    if (acc_ok) reg_rdata_o[GRP_SIZE-1:0] = sel_vec[grp_idx*GRP_SIZE +: GRP_SIZE];
  end

  assign irq_o  = |(int_sts & int_en);
  assign wake_o = |(wake_sts & wake_en & ~route_sci_i);
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int NUM_PADS = 40,
  parameter int GRP_SIZE = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2*NUM_PADS-1:0] evt_mode_i,
  input logic [NUM_PADS-1:0]   host_own_i,
  input logic [NUM_PADS-1:0]   route_sci_i,
  input logic                  reg_we_i,
  input logic [11:0]           reg_addr_i,
  input logic [31:0]           reg_rdata_o,
  input logic                  irq_o,
  input logic                  wake_o,
  input logic [NUM_PADS-1:0]   int_sts,
  input logic [NUM_PADS-1:0]   int_en,
  input logic [NUM_PADS-1:0]   wake_sts,
  input logic [NUM_PADS-1:0]   wake_en
);
  localparam int NUM_GRPS = (NUM_PADS + GRP_SIZE - 1) / GRP_SIZE;
  localparam int TAIL     = NUM_PADS - (NUM_GRPS - 1) * GRP_SIZE;

  logic [NUM_PADS-1:0] off_mask;
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_off
    assign off_mask[p] = (evt_mode_i[2*p +: 2] == 2'd2);
  end

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((int_sts | wake_sts) & ~($past(int_sts) | $past(wake_sts)) & $past(off_mask)) == '0));

  p_sts_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i[11:5] == 7'h08) |=> (($past(int_sts) & ~int_sts) == '0));

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|int_en));

  p_wake_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (|(wake_en & ~route_sci_i)));

  p_fw_no_int_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((int_sts & ~$past(int_sts) & ~$past(host_own_i)) == '0));

  p_tail_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[4:0] == 5'((NUM_GRPS - 1) * 4)) |-> ((reg_rdata_o >> TAIL) == 32'd0));
endmodule

bind gpio_evt_ctrl gpio_evt_chk #(.NUM_PADS(NUM_PADS), .GRP_SIZE(GRP_SIZE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_mode_i(evt_mode_i), .host_own_i(host_own_i),
  .route_sci_i(route_sci_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wake_o(wake_o), .int_sts(int_sts),
  .int_en(int_en), .wake_sts(wake_sts), .wake_en(wake_en)
);

// File: tb/sim_gpio_evt_ctrl.sv
module sim_gpio_evt_ctrl;
  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pad = '0, inv = '0, own = '1, sci = '0;
  logic [2*NP-1:0] mode = {NP{2'b10}};
  logic          we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, wake;
  int            n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gpio_evt_ctrl #(.NUM_PADS(NP), .GRP_SIZE(32)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pad_i(pad), .evt_mode_i(mode), .rx_inv_i(inv),
    .host_own_i(own), .route_sci_i(sci), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic chk_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic set_mode(input int p, input logic [1:0] m);
    mode[2*p +: 2] = m;
  endtask

  task automatic clr_all();
    wr(12'h100, '1); wr(12'h104, '1); wr(12'h140, '1); wr(12'h144, '1);
  endtask

  task automatic t_reset();
    foreach (u0.reg_rdata_o[i]) ; // no-op keeps bench free of internals
    chk_rd("R10 int sts g0", 12'h100, 0);
    chk_rd("R10 int sts g1", 12'h104, 0);
    chk_rd("R10 int en g0", 12'h120, 0);
    chk_rd("R10 wake sts g0", 12'h140, 0);
    chk_rd("R10 wake en g1", 12'h164, 0);
    check("R10 irq", 32'(irq), 0);
    check("R10 wake", 32'(wake), 0);
  endtask

  task automatic t_rise();
    clr_all();
    set_mode(3, 2'd1); step(1);
    pad[3] = 1'b1;
    step(2); chk_rd("R11 not after two edges", 12'h100, 0);
    step(1); chk_rd("R11/R2 rise sets", 12'h100, 32'h8);
    check("R6 irq off while disabled", 32'(irq), 0);
    chk_rd("R7 wake sts records rise", 12'h140, 32'h8);
    wr(12'h120, 32'h8); #1;
    check("R6 irq on", 32'(irq), 1);
    wr(12'h100, 32'h8);
    chk_rd("R5 w1c clears", 12'h100, 0);
    check("R6 irq off after clear", 32'(irq), 0);
    pad[3] = 1'b0; step(3);
    chk_rd("R2 fall ignored", 12'h100, 0);
    wr(12'h120, 0); set_mode(3, 2'd2);
  endtask

  task automatic t_fall();
    clr_all();
    inv[5] = 1'b1; set_mode(5, 2'd1); step(1);
    pad[5] = 1'b1; step(3);
    chk_rd("R2 inv rise ignored", 12'h100, 0);
    pad[5] = 1'b0; step(3);
    chk_rd("R2 inv fall sets", 12'h100, 32'h20);
    set_mode(5, 2'd2); step(1); inv[5] = 1'b0;
  endtask

  task automatic t_both();
    clr_all();
    set_mode(33, 2'd3); step(1);
    pad[33] = 1'b1; step(3);
    chk_rd("R3 both rise", 12'h104, 32'h2);
    wr(12'h104, 32'h2);
    chk_rd("R3 cleared", 12'h104, 0);
    pad[33] = 1'b0; step(3);
    chk_rd("R3 both fall", 12'h104, 32'h2);
    set_mode(33, 2'd2);
  endtask

  task automatic t_level();
    clr_all();
    set_mode(7, 2'd0); step(3);
    chk_rd("R4 low level idle", 12'h100, 0);
    pad[7] = 1'b1; step(3);
    chk_rd("R4 level sets", 12'h100, 32'h80);
    wr(12'h100, 32'h80);
    chk_rd("R5 event wins over clear", 12'h100, 32'h80);
    wr(12'h100, 32'h0);
    chk_rd("R5 write 0 no effect", 12'h100, 32'h80);
    pad[7] = 1'b0; step(3);
    wr(12'h100, 32'h80);
    chk_rd("R4 inactive then clear", 12'h100, 0);
    set_mode(7, 2'd2);
    // active low on pad 8, pad already low
    inv[8] = 1'b1; set_mode(8, 2'd0); step(1);
    chk_rd("R4 active low sets", 12'h100, 32'h100);
    pad[8] = 1'b1; step(3);
    wr(12'h100, 32'h100);
    chk_rd("R4 active low released", 12'h100, 0);
    set_mode(8, 2'd2); step(1); inv[8] = 1'b0; pad[8] = 1'b0;
  endtask

  task automatic t_off();
    clr_all();
    pad[10] = 1'b1; step(3); pad[10] = 1'b0; step(3);
    chk_rd("R1 off no int", 12'h100, 0);
    chk_rd("R1 off no wake", 12'h140, 0);
  endtask

  task automatic t_fw_wake();
    clr_all();
    own[12] = 1'b0; set_mode(12, 2'd1); step(1);
    pad[12] = 1'b1; step(3);
    chk_rd("R8 fw pad no int", 12'h100, 0);
    chk_rd("R8 fw pad wake sts", 12'h140, 32'h1000);
    check("R7 wake off w/o en", 32'(wake), 0);
    wr(12'h160, 32'h1000); #1;
    check("R7 wake on", 32'(wake), 1);
    sci[12] = 1'b1; #1;
    check("R7 sci route blocks", 32'(wake), 0);
    sci[12] = 1'b0; #1;
    check("R7 wake back", 32'(wake), 1);
    wr(12'h140, 32'h1000); #1;
    check("R7 wake w1c", 32'(wake), 0);
    chk_rd("R7 wake sts zero", 12'h140, 0);
    wr(12'h160, 0); set_mode(12, 2'd2); pad[12] = 1'b0; step(3); own[12] = 1'b1;
  endtask

  task automatic t_tail();
    wr(12'h124, '1);
    chk_rd("R9 tail en masked", 12'h124, 32'h0000_00ff);
    wr(12'h120, '1);
    chk_rd("R6 full group en", 12'h120, 32'hffff_ffff);
    check("R6 no irq w/o status", 32'(irq), 0);
    wr(12'h144, '1);
    chk_rd("R9 tail wake sts zero", 12'h144, 0);
    wr(12'h120, 0); wr(12'h124, 0);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_off();
    t_fw_wake();
    t_tail();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule